// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block collects interrupt events from five sources of a peripheral: two timer underflows, a time-of-day alarm, a completed serial byte and an external flag pin. Each event is latched into its own flag bit. Every bit is latched whether or not the source is enabled, so software can poll sources that it has not enabled. An enable mask selects which flags may raise the interrupt. When an enabled flag is latched, a summary bit (bit 7 of the flag register) is set and the interrupt output goes active.

The block has one register location. A read returns the flag register and clears it in the same access, which also releases the interrupt. A write updates the mask with a set/clear rule chosen by data bit 7. If a set-mode write enables a source whose flag is already pending, the interrupt rises at once, without waiting for a new event.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register reads 0x00, the mask is all zero and `irq` is low.
- R2: A high bit on `src_evt` sets the matching flag bit whether or not that source is enabled. The source-to-bit mapping is fixed: bit 0 is timer A underflow, bit 1 is timer B underflow, bit 2 is the alarm (0x04), bit 3 is serial byte complete (0x08) and bit 4 is the external pin. The flag is visible on `rdata` in the cycle after the event.
- R3: An event on an enabled source sets `rdata[7]` and drives `irq` high in the cycle after the event.
- R4: An event on a source whose mask bit is zero leaves `irq` and `rdata[7]` unchanged.
- R5: A write with `wdata[7]`=1 ORs `wdata[4:0]` into the mask and leaves the other mask bits as they were. Data bits 6:5 have no effect.
- R6: A write with `wdata[7]`=0 clears each mask bit whose `wdata` bit is 1 and keeps the others.
- R7: If a set-mode write leaves any pending flag enabled, `rdata[7]` and `irq` go high in the next cycle.
- R8: While `rd_en` is high, `rdata` shows the current register. In the next cycle all flags and bit 7 are clear and `irq` is low.
- R9: An event in the same cycle as a read is still set after the clear. If that source is enabled, it also raises `rdata[7]` and `irq`.
- R10: Bits 6:5 of `rdata` always read zero. The mask cannot be read back.
- R11: A clear-mode write does not drop an interrupt that has already been raised. Only a read releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Write strobe for the mask |
| wdata | input | 8 | Mask write data; bit 7 selects set (1) or clear (0) |
| rd_en | input | 1 | Read strobe; clears the flags after this cycle |
| rdata | output | 8 | Flag register: summary in bit 7, flags in bits 4:0 |
| irq | output | 1 | Active-high interrupt request |

## Verification
A wrong mask bit is not visible by itself. It shows only when a flag for that source is pending, or arrives, and then shows as `irq` being raised or missing one cycle after the event or the set-mode write. The bench therefore checks every pairing of mask pattern and pending flag pattern. A flag that is lost, or one that is not cleared, appears on `rdata` in the cycle after the event or the read. A stale summary bit shows as `irq` staying high after a read that had no event in the same cycle.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic            rd_en,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam int PAD = DW - 1 - NSRC;

  logic [NSRC-1:0] flag_q, mask_q, flag_n, mask_n;
  logic            sum_q, sum_n, set_wr;

  assign set_wr = wr_en & wdata[DW-1];

  always_comb begin
    mask_n = mask_q;
    if (wr_en) begin
      if (wdata[DW-1]) mask_n = mask_q | wdata[NSRC-1:0];
      else             mask_n = mask_q & ~wdata[NSRC-1:0];
    end
  end

  assign flag_n = (rd_en ? '0 : flag_q) | src_evt;
  assign sum_n  = (rd_en ? 1'b0 : sum_q)
                | (|(src_evt & mask_n))
                | (set_wr & (|(flag_n & mask_n)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      mask_q <= mask_n;
      sum_q  <= sum_n;
    end
  end

  assign rdata = {sum_q, {PAD{1'b0}}, flag_q};
  assign irq   = sum_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] src_evt,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       irq
);
  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != 5'd0) |=> ((rdata[4:0] & $past(src_evt)) == $past(src_evt))); // R2
  AST_READ_LEAVES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata[4:0] == $past(src_evt))); // R9
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src_evt == 5'd0) |=> (!irq && rdata == 8'h00)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq); // R11
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdata[4:0] != 5'd0)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:5] == 2'b00); // R10
  AST_ALL_CLEARED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[7] && wdata[4:0] == 5'h1f && !irq && !rd_en) |=> !irq); // R6
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (.*);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] src_evt = '0;
  logic       wr_en = 0;
  logic [7:0] wdata = '0;
  logic       rd_en = 0;
  logic [7:0] rdata;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl u_dut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] e, input logic w, input logic [7:0] d, input logic r);
    src_evt = e; wr_en = w; wdata = d; rd_en = r;
    @(posedge clk); #1;
    src_evt = '0; wr_en = 0; wdata = '0; rd_en = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(posedge clk); #1;
    cyc(5'h1f, 0, 0, 0);
    chk("R1 mask zero", irq, 0);
    cyc(0, 0, 0, 1);

    for (int i = 0; i < 5; i++) begin
      cyc(5'd1 << i, 0, 0, 0);
      chk("R2 bit map", rdata, 1 << i);
      cyc(0, 0, 0, 1);
    end

    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        cyc(0, 1, 8'h7f, 1);
        cyc(f[4:0], 0, 0, 0);
        chk("R2 latched", rdata, f);
        chk("R4 masked", irq, 0);
        cyc(0, 1, {3'b100, m[4:0]}, 0);
        chk("R7 pend", irq, ((f & m) != 0) ? 1 : 0);
        chk("R8 value", rdata, (((f & m) != 0) ? 8'h80 : 8'h00) | f);
        cyc(0, 0, 0, 1);
        chk("R8 cleared", rdata, 0);
        chk("R8 irq low", irq, 0);
        cyc(f[4:0], 0, 0, 0);
        chk("R3 enabled evt", {irq, rdata}, ((f & m) != 0) ? (9'h180 | f) : f);
        cyc(0, 0, 0, 1);
        cyc(0, 1, {3'b000, ~m[4:0]}, 0);
        cyc(5'h1f, 0, 0, 0);
        chk("R6 clear keeps", irq, (m != 0) ? 1 : 0);
        cyc(0, 0, 0, 1);
      end
    end

    cyc(0, 1, 8'h7f, 1);
    cyc(0, 1, 8'he0, 0);
    cyc(5'h1f, 0, 0, 0);
    chk("R5 bits 6:5 ignored", irq, 0);
    chk("R10 pad", rdata[6:5], 0);
    cyc(0, 0, 0, 1);
    cyc(0, 1, 8'h81, 0);
    cyc(0, 1, 8'h84, 0);
    cyc(5'h01, 0, 0, 0);
    chk("R5 or keeps bit0", irq, 1);
    cyc(0, 0, 0, 1);

    cyc(0, 1, 8'h90, 0);
    cyc(5'h10, 0, 0, 0);
    cyc(5'h08, 0, 0, 1);
    chk("R9 evt survives", rdata, 8'h08);
    chk("R9 masked no irq", irq, 0);
    cyc(5'h10, 0, 0, 1);
    chk("R9 enabled evt", rdata, 8'h90);
    chk("R9 irq", irq, 1);

    cyc(0, 1, 8'h1f, 0);
    chk("R11 sticky", irq, 1);
    cyc(0, 0, 0, 1);
    chk("R11 read releases", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule